// File: doc/BRIEF.md
# Word-Addressed RAM with Port-Mapped High Window

This block is the memory side of a simple processor bus. A 16-bit word address comes with a write strobe or a read strobe. An address decoder sorts each access into one of two places. Addresses below 0xFFF0 reach a small RAM built from clocked registers, one register per word. Addresses from 0xFFF0 up to 0xFFFF form the I/O window, and accesses there never touch the RAM.

In the I/O window, a write to 0xFFF0 loads a register that drives the output port. Writes to the other window addresses are dropped. A read anywhere in the window returns the input-port value, which a register samples on every clock edge. Read data is combinational from the selected source, and it is held at zero whenever no read is in progress. The strobes are plain level signals with no handshake. The bus master must never raise both strobes in the same cycle.

Top module: `mmio_ram_top`

## Requirements
- R1: While rst_n is low, and after it is released, every RAM word and out_port hold zero.
- R2: A cycle with wr_en high and addr below 0xFFF0 loads wdata into RAM word addr[1:0] at that rising edge. No other word changes. wr_en and rd_en are never high in the same cycle.
- R3: The RAM uses only addr[1:0]. Any address below 0xFFF0 with the same two low bits reaches the same word.
- R4: With rd_en high and addr below 0xFFF0, rdata shows RAM word addr[1:0] in the same cycle.
- R5: A write to any address from 0xFFF0 to 0xFFFF leaves all four RAM words unchanged.
- R6: A write to 0xFFF0 loads wdata into out_port at that rising edge. A write to 0xFFF1 through 0xFFFF leaves out_port unchanged.
- R7: With rd_en high and addr in 0xFFF0 to 0xFFFF, rdata shows the in_port value captured at the most recent rising edge, not the RAM.
- R8: With rd_en low, rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 16 | Word address |
| wdata | input | 3 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 3 | Read data, zero when idle |
| out_port | output | 3 | Output-port register |
| in_port | input | 3 | External input, sampled every cycle |

## Verification
There are two likely faults inside the block. A word enable that leaks past the decoder corrupts a RAM word. A window check that is one bit too narrow lets window writes reach the RAM, or lets RAM writes reach out_port. Either fault stays hidden until the affected word is read back, so the bench reads all four words after every write pattern that should not touch them. Faults in out_port and in the input sampling path show up one edge after the access that caused them. The input-sampling case changes in_port in the same cycle as the read, which tells a direct connection apart from a sampled one.

// File: rtl/mmio_pkg.sv
package mmio_pkg;
  typedef enum logic [1:0] {
    RGN_MEM  = 2'd0,
    RGN_OUT  = 2'd1,
    RGN_IN   = 2'd2
  } region_e;
endpackage

// File: rtl/mmio_addr_decode.sv
module mmio_addr_decode #(
  parameter int ADDR_W = 16,
  parameter int WORDS = 4,
  parameter logic [ADDR_W-1:0] IO_BASE = 16'hFFF0,
  parameter logic [ADDR_W-1:0] OUT_ADDR = 16'hFFF0
) (
  input  logic [ADDR_W-1:0] addr,
  output mmio_pkg::region_e region,
  output logic              io_hit,
  output logic [WORDS-1:0]  word_sel
);
  localparam int SEL_W = $clog2(WORDS);

  logic mem_hit;

  always_comb begin
    io_hit  = (addr >= IO_BASE);
    mem_hit = !io_hit;
    if (!io_hit)              region = mmio_pkg::RGN_MEM;
    else if (addr == OUT_ADDR) region = mmio_pkg::RGN_OUT;
    else                      region = mmio_pkg::RGN_IN;
  end

  for (genvar i = 0; i < WORDS; i++) begin : g_sel
    assign word_sel[i] = mem_hit && (addr[SEL_W-1:0] == SEL_W'(i));
  end

  always_comb begin
    if (!$isunknown(addr)) begin
      AST_SEL_ONEHOT: assert ($onehot0(word_sel)); // R2
      AST_WINDOW_NO_SEL: assert (!(io_hit && (word_sel != '0))); // R5
    end
  end
endmodule

// File: rtl/mmio_word_reg.sv
module mmio_word_reg #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q)); // R2
endmodule

// File: rtl/mmio_port_regs.sv
module mmio_port_regs #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         out_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] in_port,
  output logic [W-1:0] out_q,
  output logic [W-1:0] in_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      in_q  <= '0;
    end else begin
      in_q <= in_port;
      if (out_we) out_q <= wdata;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_we |=> $stable(out_q)); // R6
  AST_IN_SAMPLED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (in_q == $past(in_port))); // R7
endmodule

// File: rtl/mmio_ram_top.sv
module mmio_ram_top #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 3,
  parameter int WORDS = 4,
  parameter logic [ADDR_W-1:0] IO_BASE = 16'hFFF0,
  parameter logic [ADDR_W-1:0] OUT_ADDR = 16'hFFF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] out_port,
  input  logic [DATA_W-1:0] in_port
);
  import mmio_pkg::*;
  localparam int SEL_W = $clog2(WORDS);

  region_e           region;
  logic              io_hit;
  logic [WORDS-1:0]  word_sel;
  logic [DATA_W-1:0] word_q [WORDS];
  logic [DATA_W-1:0] in_q;
  logic [DATA_W-1:0] mem_rd;
  logic [WORDS*DATA_W-1:0] mem_flat;

  mmio_addr_decode #(
    .ADDR_W(ADDR_W), .WORDS(WORDS), .IO_BASE(IO_BASE), .OUT_ADDR(OUT_ADDR)
  ) u_dec (
    .addr(addr), .region(region), .io_hit(io_hit), .word_sel(word_sel)
  );

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    mmio_word_reg #(.W(DATA_W)) u_word (
      .clk(clk), .rst_n(rst_n),
      .we(wr_en && word_sel[i]),
      .d(wdata), .q(word_q[i])
    );
    assign mem_flat[i*DATA_W +: DATA_W] = word_q[i];
  end

  mmio_port_regs #(.W(DATA_W)) u_ports (
    .clk(clk), .rst_n(rst_n),
    .out_we(wr_en && (region == RGN_OUT)),
    .wdata(wdata), .in_port(in_port),
    .out_q(out_port), .in_q(in_q)
  );

  assign mem_rd = word_q[addr[SEL_W-1:0]];

  always_comb begin
    if (!rd_en)      rdata = '0;
    else if (io_hit) rdata = in_q;
    else             rdata = mem_rd;
  end

  AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en)); // R2
  AST_WINDOW_KEEPS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && io_hit) |=> $stable(mem_flat)); // R5
  AST_MEM_WR_KEEPS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !io_hit) |=> $stable(out_port)); // R6
endmodule

// File: tb/sim_mmio_ram_top.sv
module sim_mmio_ram_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [2:0]  wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  rdata, out_port;
  logic [2:0]  in_port = '0;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  mmio_ram_top u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
    .out_port(out_port), .in_port(in_port)
  );

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [2:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [2:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #2 d = rdata;
    #2 rd_en = 1'b0;
  endtask

  task automatic expect_mem(input string req, input logic [2:0] e0, input logic [2:0] e1,
                            input logic [2:0] e2, input logic [2:0] e3);
    logic [2:0] v;
    bus_read(16'h0000, v); check(req, v, e0);
    bus_read(16'h0001, v); check(req, v, e1);
    bus_read(16'h0002, v); check(req, v, e2);
    bus_read(16'h0003, v); check(req, v, e3);
  endtask

  task automatic t_reset();
    #3 check("R1 out_port in reset", out_port, 3'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check("R1 out_port after reset", out_port, 3'd0);
    expect_mem("R1", 3'd0, 3'd0, 3'd0, 3'd0);
  endtask

  task automatic t_write_read();
    bus_write(16'h0000, 3'd5);
    expect_mem("R2 single write", 3'd5, 3'd0, 3'd0, 3'd0);
    bus_write(16'h0001, 3'd3);
    bus_write(16'h0002, 3'd6);
    bus_write(16'h0003, 3'd7);
    expect_mem("R4 all words", 3'd5, 3'd3, 3'd6, 3'd7);
    bus_write(16'h0002, 3'd1);
    expect_mem("R2 overwrite", 3'd5, 3'd3, 3'd1, 3'd7);
  endtask

  task automatic t_alias();
    logic [2:0] v;
    bus_write(16'h1235, 3'd2);
    expect_mem("R3 alias write", 3'd5, 3'd2, 3'd1, 3'd7);
    bus_read(16'hFFEF, v); check("R3 alias read FFEF", v, 3'd7);
    bus_read(16'h8002, v); check("R3 alias read 8002", v, 3'd1);
  endtask

  task automatic t_io_out();
    bus_write(16'hFFF0, 3'd6);
    check("R6 out_port load", out_port, 3'd6);
    expect_mem("R5 FFF0 write", 3'd5, 3'd2, 3'd1, 3'd7);
    bus_write(16'hFFEF, 3'd4);
    check("R6 mem write keeps out_port", out_port, 3'd6);
    expect_mem("R2 FFEF write", 3'd5, 3'd2, 3'd1, 3'd4);
  endtask

  task automatic t_io_other();
    bus_write(16'hFFF1, 3'd0);
    bus_write(16'hFFF2, 3'd3);
    bus_write(16'hFFFF, 3'd1);
    check("R6 other window writes", out_port, 3'd6);
    expect_mem("R5 window writes", 3'd5, 3'd2, 3'd1, 3'd4);
  endtask

  task automatic t_in_port();
    logic [2:0] v;
    @(negedge clk); in_port = 3'd5;
    @(negedge clk); in_port = 3'd2;
    addr = 16'hFFF0; rd_en = 1'b1;
    #2 v = rdata; check("R7 sampled value at FFF0", v, 3'd5);
    #2 rd_en = 1'b0;
    bus_read(16'hFFF8, v); check("R7 read FFF8", v, 3'd2);
    bus_read(16'hFFFF, v); check("R7 read FFFF", v, 3'd2);
  endtask

  task automatic t_idle();
    @(negedge clk);
    addr = 16'h0000; rd_en = 1'b0;
    #2 check("R8 idle mem addr", rdata, 3'd0);
    addr = 16'hFFF4;
    #2 check("R8 idle window addr", rdata, 3'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_write_read();
    t_alias();
    t_io_out();
    t_io_other();
    t_in_port();
    t_idle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule